// File: doc/BRIEF.md
# Multi-Mode Timer Counter Unit

This block is a 16-bit timer/counter that only counts up. Software sets it up through a small register port with a write strobe, an address and a combinational read. One counter serves several uses. It can free-run from a divided system clock, count rising edges of an external input, or count rising edges of a partner timer's compare pin, which lets two timers be chained into a longer count. Two compare registers raise match flags when the count reaches them. A capture input latches the running count. In PWM mode the two compare registers set the period and the high time of the output pin.

Clock division never produces a derived clock. The prescaler issues a one-cycle enable pulse, and the divisor is a power of two chosen by a control field. A parameter caps that divisor. A second parameter removes the capture path completely. All events set sticky flags, which software clears by writing 1. A single interrupt output is the OR of the flags that are enabled.

Top module: `mm_timer`

## Requirements
- R1: After reset the control word, count, compare values, capture value and flags all read 0, and both the compare pin and the interrupt output are low.
- R2: Register map: address 0 is control, 1 is count, 2 is compare A, 3 is compare B, 4 is capture (read only), and 5 is flags. The control bits are: bit 0 run; bits 2:1 source (0 divided clock, 1 external count input, 2 cascade input, 3 halted); bits 6:3 divider select s; bit 7 PWM mode; bits 11:8 interrupt enables for flags 0..3; bit 12 pin enable. Compare A and compare B read back what was written.
- R3: With source 0 and run set, the count advances once every 2^s clock cycles. Values of s above log2 of the maximum divisor parameter select the maximum divisor.
- R4: When the count wraps from 0xFFFF to 0x0000, flag bit 0 is set.
- R5: With source 1, every rising edge of the external count input advances the count once. The input passes through a two-flop synchroniser first.
- R6: With source 2, every rising edge of the cascade input advances the count once.
- R7: Whenever an advance makes the count equal to compare A, flag bit 1 is set. Whenever it makes the count equal to compare B, flag bit 2 is set. Outside PWM mode, with the pin enabled, the pin toggles on each compare A match. With the pin disabled, the pin is held low.
- R8: In PWM mode the count returns to 0 on the advance after it equals compare A. The pin is high while the pin is enabled and the count is below compare B.
- R9: A rising edge on the capture input copies the current count into the capture register and sets flag bit 3.
- R10: When the capture option is disabled, the capture register reads 0 and flag bit 3 never sets, even when the capture input has an edge.
- R11: Flags stay set until a 1 is written to that bit at address 5. If a set event and a clearing write land in the same cycle, the flag stays set. The interrupt output is high when any flag is set whose enable bit is also set.
- R12: A write to the count takes priority over an advance in the same cycle. Source 3 or a cleared run bit leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data for addr (combinational) |
| ext_cnt_i | input | 1 | External count input (asynchronous) |
| ext_cap_i | input | 1 | Capture input (asynchronous) |
| casc_i | input | 1 | Partner timer compare pin, synchronous to clk |
| cmp_pin_o | output | 1 | Compare / PWM output pin |
| irq_o | output | 1 | OR of enabled flags |

## Verification
The assertions assume that the cascade input is already synchronous to the system clock. They also assume that a write to the count lands on a cycle in which no other event is judged against the value written. The external inputs need no such assumption, because they can arrive at any time. The stimulus drives every input on the falling clock edge and holds each external level for several cycles, so that each edge leaves the synchroniser as exactly one pulse. Vectors that count stop the counter before reading it back, so that every expected count is a fixed number of advances.

// File: rtl/mmt_pkg.sv
`timescale 1ns/1ps
package mmt_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPA  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMPB  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAPT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd5;

  localparam int FLG_W   = 4;
  localparam int FLG_OVF = 0;
  localparam int FLG_MA  = 1;
  localparam int FLG_MB  = 2;
  localparam int FLG_CAP = 3;

  typedef enum logic [1:0] {
    SRC_PRESC = 2'd0,
    SRC_EXT   = 2'd1,
    SRC_CASC  = 2'd2,
    SRC_HALT  = 2'd3
  } src_e;

  typedef struct packed {
    logic             pin_en;
    logic [FLG_W-1:0] irq_en;
    logic             pwm;
    logic [3:0]       div_sel;
    src_e             src;
    logic             run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/mmt_rst_sync.sv
`timescale 1ns/1ps
module mmt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_s = stage_q[1];
endmodule

// File: rtl/mmt_edge_det.sv
`timescale 1ns/1ps
module mmt_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic pulse
);
  logic lvl;
  logic prev_q;

  generate
    if (STAGES == 0) begin : g_direct
      assign lvl = din;
    end else begin : g_sync
      logic [STAGES-1:0] sync_q;
      logic [STAGES-1:0] sync_d;
      always_comb sync_d = (sync_q << 1) | STAGES'(din);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
      end
      assign lvl = sync_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign pulse = lvl & ~prev_q;

  // R5 / R6: each level rise yields one single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/mmt_prescaler.sv
`timescale 1ns/1ps
module mmt_prescaler #(
  parameter int PS_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] sel,
  output logic       tick
);
  logic [PS_W-1:0] pcnt_q;
  logic [PS_W-1:0] pcnt_d;
  logic [PS_W-1:0] mask;

  always_comb begin
    mask   = ~({PS_W{1'b1}} << sel);
    pcnt_d = run ? pcnt_q + 1'b1 : '0;
    tick   = run & ((pcnt_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R12: a stopped prescaler restarts its phase from zero
  a_r12_phase_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pcnt_q == '0);
endmodule

// File: rtl/mmt_capture.sv
`timescale 1ns/1ps
module mmt_capture #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] capt_o,
  output logic             evt_o
);
  logic             cap_pulse;
  logic [CNT_W-1:0] capt_q;
  logic [CNT_W-1:0] capt_d;

  mmt_edge_det #(.STAGES(SYNC_STAGES)) u_cap_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (cap_i),
    .pulse (cap_pulse)
  );

  always_comb capt_d = cap_pulse ? cnt_i : capt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) capt_q <= '0;
    else        capt_q <= capt_d;
  end

  assign capt_o = capt_q;
  assign evt_o  = cap_pulse;

  // R9: the captured value is the count seen on the event cycle
  a_r9_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |=> capt_q == $past(cnt_i));
endmodule

// File: rtl/mm_timer.sv
`timescale 1ns/1ps
module mm_timer #(
  parameter int CNT_W         = 16,
  parameter int PRESC_MAX_DIV = 128,
  parameter bit HAS_CAPTURE   = 1'b1,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [mmt_pkg::ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]          wdata,
  output logic [CNT_W-1:0]          rd_data,
  input  logic                      ext_cnt_i,
  input  logic                      ext_cap_i,
  input  logic                      casc_i,
  output logic                      cmp_pin_o,
  output logic                      irq_o
);
  import mmt_pkg::*;

  localparam int PS_W = $clog2(PRESC_MAX_DIV);

  logic                rst_n_s;
  ctrl_t               ctrl_q, ctrl_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [CNT_W-1:0]    cmpa_q, cmpa_d;
  logic [CNT_W-1:0]    cmpb_q, cmpb_d;
  logic [FLG_W-1:0]    flags_q, flags_d, flag_set, flag_clr;
  logic                tog_q, tog_d;
  logic [CNT_W-1:0]    capt_val;
  logic                cap_evt;
  logic                presc_tick, ext_pulse, casc_pulse;
  logic                src_pulse, tick;
  logic                ctrl_wr, cnt_wr, cmpa_wr, cmpb_wr, flag_wr;
  logic [CNT_W-1:0]    inc_val;
  logic                period_end;
  logic                ovf_evt, ma_evt, mb_evt;

  mmt_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  mmt_prescaler #(.PS_W(PS_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n_s),
    .run   (ctrl_q.run),
    .sel   (ctrl_q.div_sel),
    .tick  (presc_tick)
  );

  mmt_edge_det #(.STAGES(SYNC_STAGES)) u_ext_edge (
    .clk   (clk),
    .rst_n (rst_n_s),
    .din   (ext_cnt_i),
    .pulse (ext_pulse)
  );

  mmt_edge_det #(.STAGES(0)) u_casc_edge (
    .clk   (clk),
    .rst_n (rst_n_s),
    .din   (casc_i),
    .pulse (casc_pulse)
  );

  generate
    if (HAS_CAPTURE) begin : g_cap
      mmt_capture #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n_s),
        .cap_i  (ext_cap_i),
        .cnt_i  (cnt_q),
        .capt_o (capt_val),
        .evt_o  (cap_evt)
      );
    end else begin : g_nocap
      logic unused_cap;
      assign unused_cap = ext_cap_i;
      assign capt_val   = '0;
      assign cap_evt    = 1'b0;
    end
  endgenerate

  // write decode
  always_comb begin
    ctrl_wr = wr_en && (addr == A_CTRL);
    cnt_wr  = wr_en && (addr == A_CNT);
    cmpa_wr = wr_en && (addr == A_CMPA);
    cmpb_wr = wr_en && (addr == A_CMPB);
    flag_wr = wr_en && (addr == A_FLAGS);
  end

  // advance source selection
  always_comb begin
    unique case (ctrl_q.src)
      SRC_PRESC: src_pulse = presc_tick;
      SRC_EXT:   src_pulse = ext_pulse;
      SRC_CASC:  src_pulse = casc_pulse;
      default:   src_pulse = 1'b0;
    endcase
    tick = ctrl_q.run & src_pulse;
  end

  // count, events and pin next state
  always_comb begin
    period_end = ctrl_q.pwm && (cnt_q == cmpa_q);
    inc_val    = period_end ? '0 : cnt_q + 1'b1;

    ovf_evt = tick && !cnt_wr && (cnt_q == {CNT_W{1'b1}});
    ma_evt  = tick && !cnt_wr && (inc_val == cmpa_q);
    mb_evt  = tick && !cnt_wr && (inc_val == cmpb_q);

    if (cnt_wr)    cnt_d = wdata;
    else if (tick) cnt_d = inc_val;
    else           cnt_d = cnt_q;

    ctrl_d = ctrl_wr ? ctrl_t'(wdata[CTRL_W-1:0]) : ctrl_q;
    cmpa_d = cmpa_wr ? wdata : cmpa_q;
    cmpb_d = cmpb_wr ? wdata : cmpb_q;

    flag_set = '0;
    flag_set[FLG_OVF] = ovf_evt;
    flag_set[FLG_MA]  = ma_evt;
    flag_set[FLG_MB]  = mb_evt;
    flag_set[FLG_CAP] = cap_evt;
    flag_clr = flag_wr ? wdata[FLG_W-1:0] : '0;
    flags_d  = (flags_q & ~flag_clr) | flag_set;

    if (!ctrl_q.pin_en)              tog_d = 1'b0;
    else if (ma_evt && !ctrl_q.pwm)  tog_d = ~tog_q;
    else                             tog_d = tog_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctrl_q  <= '0;
      cnt_q   <= '0;
      cmpa_q  <= '0;
      cmpb_q  <= '0;
      flags_q <= '0;
      tog_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      cnt_q   <= cnt_d;
      cmpa_q  <= cmpa_d;
      cmpb_q  <= cmpb_d;
      flags_q <= flags_d;
      tog_q   <= tog_d;
    end
  end

  // outputs
  always_comb begin
    if (ctrl_q.pwm) cmp_pin_o = ctrl_q.pin_en && (cnt_q < cmpb_q);
    else            cmp_pin_o = tog_q;
    irq_o = |(flags_q & ctrl_q.irq_en);
  end

  always_comb begin
    unique case (addr)
      A_CTRL:  rd_data = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      A_CNT:   rd_data = cnt_q;
      A_CMPA:  rd_data = cmpa_q;
      A_CMPB:  rd_data = cmpb_q;
      A_CAPT:  rd_data = capt_val;
      A_FLAGS: rd_data = {{(CNT_W-FLG_W){1'b0}}, flags_q};
      default: rd_data = '0;
    endcase
  end

  // R4: wrap sets the overflow flag and lands on zero
  a_r4_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tick && !cnt_wr && (cnt_q == {CNT_W{1'b1}})) |=> (flags_q[FLG_OVF] && cnt_q == '0));

  // R11: a set flag survives unless a 1 is written to it
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n_s)
    (flags_q[FLG_OVF] && !(flag_wr && wdata[FLG_OVF])) |=> flags_q[FLG_OVF]);

  // R12: count write has priority
  a_r12_load: assert property (@(posedge clk) disable iff (!rst_n_s)
    cnt_wr |=> cnt_q == $past(wdata));

  // R12: no advance, no change
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!tick && !cnt_wr) |=> $stable(cnt_q));

  // R7: pin disabled outside PWM keeps the pin low
  a_r7_pin_off: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ctrl_q.pin_en && !ctrl_wr) |=> !cmp_pin_o);
endmodule

// File: tb/mm_timer_tb.sv
`timescale 1ns/1ps
module mm_timer_tb;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rd_data;
  logic [15:0] rd_nc;
  logic        ext_cnt_i, ext_cap_i, casc_i;
  logic        cmp_pin_o, irq_o;
  logic        pin_nc, irq_nc;

  int n_chk;
  int n_fail;

  mm_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .ext_cnt_i(ext_cnt_i), .ext_cap_i(ext_cap_i),
    .casc_i(casc_i), .cmp_pin_o(cmp_pin_o), .irq_o(irq_o)
  );

  mm_timer #(.HAS_CAPTURE(1'b0)) u_nocap (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_nc), .ext_cnt_i(ext_cnt_i), .ext_cap_i(ext_cap_i),
    .casc_i(casc_i), .cmp_pin_o(pin_nc), .irq_o(irq_nc)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [15:0] ctrl;
    logic [15:0] load;
    logic [15:0] cmpa;
    logic [15:0] cmpb;
    logic [15:0] ncyc;
    logic [15:0] exp_cnt;
    logic [3:0]  exp_flg;
    logic        exp_pin;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 16'h0000, 16'h0100, 16'h0200, 16'd10,  16'd10,   4'h0, 1'b0}, // R3 div 1
    '{16'h0018, 16'h0000, 16'h0100, 16'h0200, 16'd40,  16'd5,    4'h0, 1'b0}, // R3 div 8
    '{16'h0000, 16'hFFFC, 16'h0100, 16'h0200, 16'd6,   16'd2,    4'h1, 1'b0}, // R4 wrap
    '{16'h1000, 16'h0000, 16'h0005, 16'h0003, 16'd8,   16'd8,    4'h6, 1'b1}, // R7 compare
    '{16'h1080, 16'h0000, 16'h0004, 16'h0002, 16'd7,   16'd2,    4'h6, 1'b0}, // R8 pwm
    '{16'h1088, 16'h0000, 16'h0009, 16'h0009, 16'd9,   16'd4,    4'h0, 1'b1}, // R8 pwm div 2
    '{16'h0078, 16'h0000, 16'h0100, 16'h0200, 16'd256, 16'd2,    4'h0, 1'b0}, // R3 clip to 128
    '{16'h0006, 16'h1234, 16'h0100, 16'h0200, 16'd20,  16'h1234, 4'h0, 1'b0}  // R12 halted
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    ext_cnt_i = 1'b0; ext_cap_i = 1'b0; casc_i = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state
    rd(3'd0, v); chk("R1 ctrl", v, 16'h0);
    rd(3'd1, v); chk("R1 count", v, 16'h0);
    rd(3'd4, v); chk("R1 capture", v, 16'h0);
    rd(3'd5, v); chk("R1 flags", v, 16'h0);
    chk("R1 pin", {15'd0, cmp_pin_o}, 16'h0);
    chk("R1 irq", {15'd0, irq_o}, 16'h0);

    // table of vectors
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      wr(3'd5, 16'h000F);
      wr(3'd1, VECS[k].load);
      wr(3'd2, VECS[k].cmpa);
      wr(3'd3, VECS[k].cmpb);
      wr(3'd0, VECS[k].ctrl | 16'h0001);
      idle(int'(VECS[k].ncyc) - 1);
      wr(3'd0, VECS[k].ctrl);
      rd(3'd1, v); chk($sformatf("R3/R12 vec%0d count", k), v, VECS[k].exp_cnt);
      rd(3'd5, v); chk($sformatf("R4/R7 vec%0d flags", k), v, {12'd0, VECS[k].exp_flg});
      chk($sformatf("R7/R8 vec%0d pin", k), {15'd0, cmp_pin_o}, {15'd0, VECS[k].exp_pin});
    end

    // R2: register readback
    @(negedge clk);
    wr(3'd2, 16'hBEEF);
    rd(3'd2, v); chk("R2 cmpa readback", v, 16'hBEEF);
    wr(3'd0, 16'h1F86);
    rd(3'd0, v); chk("R2 ctrl readback", v, 16'h1F86);

    // R5: external count via synchroniser
    wr(3'd0, 16'h0000);
    wr(3'd5, 16'h000F);
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h0003);
    for (int p = 0; p < 3; p++) begin
      ext_cnt_i = 1'b1; idle(3);
      ext_cnt_i = 1'b0; idle(3);
    end
    idle(4);
    wr(3'd0, 16'h0000);
    rd(3'd1, v); chk("R5 external edges", v, 16'd3);

    // R6: cascade input
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h0005);
    for (int p = 0; p < 4; p++) begin
      casc_i = 1'b1; idle(1);
      casc_i = 1'b0; idle(1);
    end
    idle(2);
    wr(3'd0, 16'h0000);
    rd(3'd1, v); chk("R6 cascade edges", v, 16'd4);

    // R9 / R10 / R11: capture, no-capture build, interrupt
    wr(3'd5, 16'h000F);
    wr(3'd1, 16'h0ABC);
    wr(3'd0, 16'h0800);
    ext_cap_i = 1'b1; idle(3);
    ext_cap_i = 1'b0; idle(4);
    rd(3'd4, v); chk("R9 capture value", v, 16'h0ABC);
    rd(3'd5, v); chk("R9 capture flag", v, 16'h0008);
    chk("R11 irq on enabled flag", {15'd0, irq_o}, 16'h1);
    addr = 3'd4; #1; chk("R10 no capture register", rd_nc, 16'h0);
    addr = 3'd5; #1; chk("R10 no capture flag", rd_nc, 16'h0);
    @(negedge clk);
    wr(3'd5, 16'h0008);
    rd(3'd5, v); chk("R11 w1c clears", v, 16'h0);
    chk("R11 irq drops", {15'd0, irq_o}, 16'h0);

    // R11: set wins over clear in the same cycle
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'hFFFF);
    wr(3'd0, 16'h0001);
    wr(3'd5, 16'h0001);
    wr(3'd0, 16'h0000);
    rd(3'd5, v); chk("R11 set beats clear", v, 16'h0001);
    wr(3'd5, 16'h0001);
    rd(3'd5, v); chk("R11 later clear", v, 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule